// File: doc/BRIEF.md
# Latch-Based Word Register File with Gated Write Clocks

This block is a small word-addressable storage array in which every word is held in a bank of level-sensitive latches instead of edge-triggered flops. A write is taken in two steps. At the rising clock edge the incoming word is captured into a single shared capture register and the write address is turned into a one-hot bank select. During the low half of that same cycle, only the selected bank's latch opens and copies the captured word. Both the capture register and each bank run from their own gated clock. Each gated clock is built from an enable latch followed by an AND gate, so a change of enable can never produce a glitch on the gated clock.

Reading is purely combinational: a multiplexer indexed by the read address drives the read data port with no register in between. A word written at a rising edge can be read before the next rising edge. Seen from the ports, the array therefore behaves like a flop-based register file with one write port and one asynchronous read port. The depth is a parameter (2, 4, 8 or 16 words) and each word is 32 bits wide. A synchronous active-high reset clears every word to zero.

Top module: `latch_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every word is cleared to zero. In the first cycle after `rst` is released, every read address returns 0.
- R2: A write with `wr_en` high at a rising edge changes only the word at `wr_addr`. The address is decoded so that at most one bank select is active at any time, and all other words keep their values.
- R3: The capture register loads `wr_data` only at edges where `wr_en` (or `rst`) is high, and it holds its value otherwise. A stored word therefore keeps the data presented at its write edge, even when `wr_data` changes afterwards.
- R4: A word written at rising edge N appears on `rd_data` for that address before rising edge N+1. In the cycle in which the write is being presented (before edge N), a read of the same address still returns the previous contents.
- R5: `rd_data` equals the word at `rd_addr` in the same cycle, with no added clock of latency. Changing `rd_addr` changes `rd_data` within that cycle.
- R6: Writes to the same address at consecutive edges take effect in order. After each edge the word holds the most recently written value.
- R7: At edges where `wr_en` is low, no word changes, whatever values `wr_addr` and `wr_data` carry.
- R8: Address 0 and address DEPTH-1 are independent storage locations. The address width is ceil(log2(DEPTH)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; capture on rising edge, bank transfer in low phase |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| wr_en | input | 1 | Write request for this edge |
| wr_addr | input | ADDR_W | Word index to write |
| wr_data | input | 32 | Word to write |
| rd_addr | input | ADDR_W | Word index to read |
| rd_data | output | 32 | Combinational read data |

## Verification
The hardest situation to provoke is a write that follows immediately on a previous write to the same bank. In that case the capture register must be overwritten exactly while the bank's latch is closing, and a one-phase slip in either gated clock would leave the older value in the bank. The stimulus forces this case directly: a run of consecutive writes to one address, each read back in its own cycle. Long random traffic is then biased so that roughly half of all writes repeat the previous address. Same-cycle reads of the address being written pin down the boundary between old and new contents.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

    // Word width of every storage bank.
    parameter int unsigned LRF_WORD_W = 32;

    typedef logic [LRF_WORD_W-1:0] word_t;

    // Which clock phase a gated clock is allowed to pulse in.
    typedef enum logic {
        PULSE_HIGH_PHASE = 1'b0,   // gated clock follows clk high phase
        PULSE_LOW_PHASE  = 1'b1    // gated clock follows clk low phase
    } gate_phase_e;

    // Write request as seen by the capture stage.
    typedef struct packed {
        logic  en;
        logic  clear;
        word_t data;
    } cap_req_t;

    // Address width for a given word count (at least one bit).
    function automatic int unsigned addr_bits(input int unsigned depth);
        int unsigned w;
        w = 1;
        while ((1 << w) < depth) w++;
        return w;
    endfunction

    // Build the capture request from port values; reset forces zero data.
    function automatic cap_req_t make_req(input logic rst, input logic we,
                                          input word_t wd);
        cap_req_t r;
        r.en    = we | rst;
        r.clear = rst;
        r.data  = rst ? '0 : wd;
        return r;
    endfunction

endpackage

// File: rtl/lrf_clk_gate.sv
module lrf_clk_gate
    import lrf_pkg::*;
#(
    parameter gate_phase_e PHASE = PULSE_HIGH_PHASE
) (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);

    logic en_held;

    generate
        if (PHASE == PULSE_HIGH_PHASE) begin : g_high
            // Enable may only change while clk is low; pulse follows clk.
            always_latch begin
                if (!clk_i) en_held <= en_i;
            end
            assign gclk_o = clk_i & en_held;
        end else begin : g_low
            // Enable may only change while clk is high; pulse follows ~clk.
            always_latch begin
                if (clk_i) en_held <= en_i;
            end
            assign gclk_o = ~clk_i & en_held;
        end
    endgenerate

endmodule

// File: rtl/lrf_capture_stage.sv
module lrf_capture_stage
    import lrf_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    output word_t             cap_word,
    output logic [DEPTH-1:0]  bank_sel
);

    cap_req_t          req;
    logic              cap_gclk;
    logic [DEPTH-1:0]  decoded;

    assign req = make_req(rst, we, wdata);

    // Gated clock for the shared capture register.
    lrf_clk_gate #(.PHASE(PULSE_HIGH_PHASE)) u_cap_gate (
        .clk_i  (clk),
        .en_i   (req.en),
        .gclk_o (cap_gclk)
    );

    always_ff @(posedge cap_gclk) begin
        cap_word <= req.data;
    end

    // Address decoder: one comparator per bank.
    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_dec
            assign decoded[gi] = (waddr == ADDR_W'(gi));
        end
    endgenerate

    // Bank select register: all banks during reset, one bank on a write.
    always_ff @(posedge clk) begin
        if (req.clear) begin
            bank_sel <= '1;
        end else if (req.en) begin
            bank_sel <= decoded;
        end else begin
            bank_sel <= '0;
        end
    end

endmodule

// File: rtl/lrf_word_bank.sv
module lrf_word_bank
    import lrf_pkg::*;
(
    input  logic  clk,
    input  logic  sel_i,
    input  word_t d_i,
    output word_t q_o
);

    logic bank_gclk;

    // Each bank owns a gated clock that pulses in the low phase.
    lrf_clk_gate #(.PHASE(PULSE_LOW_PHASE)) u_bank_gate (
        .clk_i  (clk),
        .en_i   (sel_i),
        .gclk_o (bank_gclk)
    );

    always_latch begin
        if (bank_gclk) q_o <= d_i;
    end

endmodule

// File: rtl/lrf_read_mux.sv
module lrf_read_mux
    import lrf_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input  logic [DEPTH-1:0][LRF_WORD_W-1:0] words,
    input  logic [ADDR_W-1:0]                raddr,
    output word_t                            rdata
);

    localparam int unsigned SPAN = 1 << ADDR_W;

    // Pad to a power of two so every address decodes to a defined word.
    logic [SPAN-1:0][LRF_WORD_W-1:0] padded;

    genvar gi;
    generate
        for (gi = 0; gi < SPAN; gi++) begin : g_pad
            if (gi < DEPTH) begin : g_real
                assign padded[gi] = words[gi];
            end else begin : g_fill
                assign padded[gi] = '0;
            end
        end
    endgenerate

    assign rdata = padded[raddr];

endmodule

// File: rtl/latch_regfile.sv
module latch_regfile
    import lrf_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [LRF_WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [LRF_WORD_W-1:0] rd_data
);

    word_t                           cap_word;
    logic [DEPTH-1:0]                bank_sel;
    logic [DEPTH-1:0][LRF_WORD_W-1:0] store;

    lrf_capture_stage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .cap_word (cap_word),
        .bank_sel (bank_sel)
    );

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_bank
            lrf_word_bank u_bank (
                .clk   (clk),
                .sel_i (bank_sel[gi]),
                .d_i   (cap_word),
                .q_o   (store[gi])
            );
        end
    endgenerate

    lrf_read_mux #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_rmux (
        .words (store),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/latch_regfile_chk.sv
module latch_regfile_chk
    import lrf_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned ADDR_W = addr_bits(DEPTH)
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             wr_en,
    input logic [ADDR_W-1:0]                wr_addr,
    input logic [LRF_WORD_W-1:0]            wr_data,
    input logic [ADDR_W-1:0]                rd_addr,
    input logic [LRF_WORD_W-1:0]            rd_data,
    input logic [DEPTH-1:0]                 bank_sel,
    input logic [LRF_WORD_W-1:0]            cap_word,
    input logic [DEPTH-1:0][LRF_WORD_W-1:0] store
);

    // Set once an edge has passed with reset low.
    logic settled;
    always_ff @(posedge clk) settled <= !rst;

    AST_SELECT_ONEHOT: assert property (@(posedge clk) disable iff (rst || !settled)
        $onehot0(bank_sel)); // R2

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (rst || !settled)
        $past(wr_en) |-> cap_word == $past(wr_data)); // R3

    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (rst || !settled)
        !$past(wr_en) |-> $stable(cap_word)); // R3

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && !rst) |-> store[$past(wr_addr)] == $past(wr_data)); // R4

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst || !settled)
        ($stable(rd_addr) && !$past(wr_en)) |-> $stable(rd_data)); // R5

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_word
            AST_OTHER_WORDS_KEEP: assert property (@(posedge clk) disable iff (rst || !settled)
                !($past(wr_en) && $past(wr_addr) == ADDR_W'(gi)) |-> $stable(store[gi])); // R7
        end
    endgenerate

endmodule

bind latch_regfile latch_regfile_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .bank_sel (bank_sel),
    .cap_word (cap_word),
    .store    (store)
);

// File: tb/latch_regfile_test.sv
`timescale 1ns/1ps
module latch_regfile_test;

    localparam int DEPTH  = 8;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        int          addr;
        string       tag;
    } item_t;

    item_t       sb[$];
    logic [31:0] model_mem [DEPTH];

    always #2.5 clk = ~clk;

    latch_regfile #(.DEPTH(DEPTH)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Monitor: compare late in the low phase of each cycle.
    initial begin
        forever begin
            @(posedge clk);
            #4;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %0d actual %h expected %h",
                             it.tag, it.addr, rd_data, it.exp);
                end
            end
        end
    end

    // Drive one cycle; the read expects contents from earlier writes only.
    task automatic cycle(input bit we, input int wa, input logic [31:0] wd,
                         input int ra, input string tag, input bit chk);
        @(posedge clk);
        #1;
        rst     = 1'b0;
        wr_en   = we;
        wr_addr = ADDR_W'(wa);
        wr_data = wd;
        rd_addr = ADDR_W'(ra);
        if (chk) sb.push_back('{exp: model_mem[ra], addr: ra, tag: tag});
        if (we) model_mem[wa] = wd;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst     = 1'b1;
        wr_en   = 1'b1;          // ignored while in reset
        wr_data = 32'hFFFF_FFFF;
        repeat (2) @(posedge clk);
        for (int i = 0; i < DEPTH; i++) model_mem[i] = '0;
    endtask

    initial begin
        int last_a;
        do_reset();

        // R1: all words zero right after reset
        for (int a = 0; a < DEPTH; a++) cycle(0, 0, 32'h0, a, "R1", 1);

        // R4: same-cycle read shows old, next cycle shows new
        cycle(1, 0, 32'hA5A5_0001, 0, "R4", 1);
        cycle(0, 0, 32'h0, 0, "R4", 1);

        // R2 / R8: fill each word while reading a neighbour
        for (int a = 0; a < DEPTH; a++)
            cycle(1, a, 32'h1000_0000 + a * 32'h111, (a + 1) % DEPTH, "R2", 1);
        cycle(0, 0, 32'h0, 0, "R8", 1);
        cycle(0, 0, 32'h0, DEPTH - 1, "R8", 1);

        // R6: back-to-back writes to one address, read each cycle
        cycle(1, 2, 32'hB000_0001, 2, "R6", 1);
        cycle(1, 2, 32'hB000_0002, 2, "R6", 1);
        cycle(1, 2, 32'hB000_0003, 2, "R6", 1);
        cycle(0, 5, 32'hDEAD_BEEF, 2, "R6", 1);

        // R3: data changing after the write edge does not reach the bank
        cycle(1, 4, 32'hC0DE_0004, 4, "R3", 1);
        cycle(0, 4, 32'h1234_5678, 4, "R3", 1);
        cycle(0, 4, 32'h8765_4321, 4, "R3", 1);

        // R7: write enable low with toggling address and data
        for (int k = 0; k < 8; k++)
            cycle(0, k, ~(32'h1 << k), k, "R7", 1);

        // R5: read address changes every cycle with no writes
        for (int k = 0; k < 2 * DEPTH; k++)
            cycle(0, 0, 32'h0, (k * 3) % DEPTH, "R5", 1);

        // R2 / R6: random traffic biased to repeat the last write address
        last_a = 0;
        for (int k = 0; k < 600; k++) begin
            bit we;
            int wa;
            we = ($urandom_range(0, 3) != 0);
            wa = ($urandom_range(0, 1) == 1) ? last_a : $urandom_range(0, DEPTH - 1);
            if (we) last_a = wa;
            cycle(we, wa, $urandom(), $urandom_range(0, DEPTH - 1), "R6", 1);
        end

        // R1: reset again with data present
        do_reset();
        for (int a = 0; a < DEPTH; a++) cycle(0, 0, 32'h0, a, "R1", 1);

        cycle(0, 0, 32'h0, 0, "R1", 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule